// File: doc/BRIEF.md
# SPI Byte Receiver with Four-Phase Clock-Domain Handshake

This block collects bits from an SPI master and delivers each finished byte to logic running on an unrelated bus clock. The capture shift register and its bit counter run directly on the rising edge of the serial clock, with no oversampling. When eight bits have arrived under an active (low) chip-select, the byte is parked in a holding register and a request level is raised toward the bus side.

The bus side sees the request through a two-flop synchronizer, takes the parked byte, and raises an acknowledge level. The serial side sees that acknowledge through its own two-flop synchronizer and drops the request. The bus side then drops the acknowledge once the low request reaches it. A new byte is offered only after the serial side has seen the acknowledge go low again. Each delivered byte appears on the bus side as a byte value together with a one-cycle valid strobe.

The serial side advances the handshake only on serial clock edges, so a master that keeps the clock running between bytes sees the handshake close on its own. A byte that completes while a handshake is still open is dropped.

Top module: `spi_byte_xfer`

## Requirements
- R1: While `rst_n` is low and for the bus cycles after it, `rx_valid` is 0 and `rx_byte` is 0x00. No byte is reported until one has been shifted in.
- R2: With `spi_cs_n` low, `spi_mosi` is sampled on each rising `spi_sck` edge, most significant bit first. The eighth edge completes a byte whose value is the eight sampled bits in arrival order.
- R3: Each accepted byte produces exactly one `rx_valid` pulse, one bus-clock cycle wide. `rx_byte` carries that byte in the same cycle.
- R4: Raising `spi_cs_n` clears the bit count at once. Bits of an unfinished byte are discarded, and the next byte starts from bit 7 once `spi_cs_n` falls again.
- R5: A byte that completes while the previous request/acknowledge exchange is still open is discarded. The byte already in flight is delivered unchanged.
- R6: The request rises only when the serial side sees both its own request and the synchronized acknowledge low. The holding register does not change while the request is high.
- R7: The request falls only after the synchronized acknowledge has been seen high. The acknowledge falls only after the synchronized request has been seen low. After a full exchange, the next completed byte is accepted.
- R8: When the bus clock runs well above the serial clock, bytes sent back to back within one chip-select frame are all delivered, in order.
- R9: Between valid strobes, `rx_byte` keeps the value of the most recently delivered byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus-domain clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| spi_sck | input | 1 | Serial clock from the SPI master; capture uses its rising edge |
| spi_cs_n | input | 1 | Active-low chip-select; high clears the bit count |
| spi_mosi | input | 1 | Serial data from the master, most significant bit first |
| rx_byte | output | 8 | Last byte delivered into the bus domain |
| rx_valid | output | 1 | One-cycle strobe marking a newly delivered byte |

## Verification
The bench sends all 256 byte values back to back in one frame. A wrong bit order, an off-by-one counter, or a lost handshake shows up there as a wrong or missing entry. It aborts bytes partway and then sends full bytes. A counter that survives chip-select release would splice the stale bits into the next byte. It stops the bus clock while two bytes arrive. A design that overwrote the holding register or raised a second request would deliver the second byte or a corrupted first one, and a handshake that never closed would lose the byte sent after the bus clock restarts.

// File: rtl/spi_xfer_pkg.sv
// Shared width and type definitions for the SPI byte receiver.
package spi_xfer_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(BYTE_W);
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  bitcnt_t;
endpackage

// File: rtl/spi_level_sync.sv
// Multi-flop level synchronizer.
// Assumes: d_in is a slowly changing level from another clock domain.
module spi_level_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/spi_bit_shifter.sv
// Serial capture: shifts MOSI in MSB first on rising SCK and flags the
// edge that completes a byte.
// Assumes: cs_n high acts as an immediate clear of the bit count.
module spi_bit_shifter
    import spi_xfer_pkg::*;
(
    input  logic    sck,
    input  logic    cs_n,
    input  logic    rst_n,
    input  logic    mosi,
    output logic    byte_done,
    output byte_t   byte_val,
    output bitcnt_t bit_cnt
);
    localparam bitcnt_t LAST_BIT = bitcnt_t'(BYTE_W - 1);

    logic [BYTE_W-2:0] shreg;

    // Bit counter, cleared asynchronously while chip-select is released.
    always_ff @(posedge sck or posedge cs_n) begin
        if (cs_n)        bit_cnt <= '0;
        else if (!rst_n) bit_cnt <= '0;
        else             bit_cnt <= bit_cnt + 1'b1;
    end

    // Shift register holding the bits received so far in this byte.
    always_ff @(posedge sck) begin
        if (!rst_n)     shreg <= '0;
        else if (!cs_n) shreg <= {shreg[BYTE_W-3:0], mosi};
    end

    assign byte_done = !cs_n && (bit_cnt == LAST_BIT);
    assign byte_val  = {shreg, mosi};
endmodule

// File: rtl/spi_req_side.sv
// Serial-domain half of the four-phase handshake: parks a finished byte
// and raises the request; lowers it once the acknowledge is seen.
// Assumes: ack_seen is already synchronized to sck.
module spi_req_side
    import spi_xfer_pkg::*;
(
    input  logic  sck,
    input  logic  rst_n,
    input  logic  byte_done,
    input  byte_t byte_val,
    input  logic  ack_seen,
    output logic  req,
    output byte_t hold_byte
);
    logic ready;
    assign ready = !req && !ack_seen;

    // Request level and holding register; busy-time bytes are dropped.
    always_ff @(posedge sck) begin
        if (!rst_n) begin
            req       <= 1'b0;
            hold_byte <= '0;
        end else if (byte_done && ready) begin
            hold_byte <= byte_val;
            req       <= 1'b1;
        end else if (req && ack_seen) begin
            req <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_ack_side.sv
// Bus-domain half of the handshake: on a synchronized request, samples the
// parked byte, raises acknowledge, and issues a one-cycle valid strobe.
// Assumes: hold_byte is stable whenever req_seen is high.
module spi_ack_side
    import spi_xfer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req_seen,
    input  byte_t hold_byte,
    output logic  ack,
    output byte_t rx_byte,
    output logic  rx_valid
);
    logic take;
    assign take = req_seen && !ack;

    // Acknowledge follows the synchronized request level.
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= req_seen;
    end

    // Capture the byte and strobe valid on the acknowledge rising cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= take;
            if (take) rx_byte <= hold_byte;
        end
    end
endmodule

// File: rtl/spi_byte_xfer.sv
// Top: SPI byte receiver clocked by SCK, handing bytes to the bus clock
// domain through a four-phase request/acknowledge handshake.
// Assumes: spi_sck and bus_clk are unrelated; bus_clk is several times faster.
module spi_byte_xfer
    import spi_xfer_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        bus_clk,
    input  logic        rst_n,
    input  logic        spi_sck,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic [7:0]  rx_byte,
    output logic        rx_valid
);
    logic    byte_done;
    byte_t   byte_val;
    bitcnt_t bit_cnt;
    logic    spi_req;
    logic    spi_ack_seen;
    byte_t   hold_byte;
    logic    bus_req_seen;
    logic    bus_ack;
    byte_t   bus_byte;

    spi_bit_shifter shift_i (
        .sck(spi_sck), .cs_n(spi_cs_n), .rst_n(rst_n), .mosi(spi_mosi),
        .byte_done(byte_done), .byte_val(byte_val), .bit_cnt(bit_cnt)
    );

    spi_req_side req_i (
        .sck(spi_sck), .rst_n(rst_n), .byte_done(byte_done),
        .byte_val(byte_val), .ack_seen(spi_ack_seen),
        .req(spi_req), .hold_byte(hold_byte)
    );

    spi_level_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
        .clk(spi_sck), .rst_n(rst_n), .d_in(bus_ack), .q_out(spi_ack_seen)
    );

    spi_level_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
        .clk(bus_clk), .rst_n(rst_n), .d_in(spi_req), .q_out(bus_req_seen)
    );

    spi_ack_side ack_i (
        .clk(bus_clk), .rst_n(rst_n), .req_seen(bus_req_seen),
        .hold_byte(hold_byte), .ack(bus_ack),
        .rx_byte(bus_byte), .rx_valid(rx_valid)
    );

    assign rx_byte = bus_byte;
endmodule

// File: rtl/spi_byte_xfer_chk.sv
// Protocol checker for spi_byte_xfer, attached by bind below.
module spi_byte_xfer_chk (
    input logic       bus_clk,
    input logic       spi_sck,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic [2:0] bit_cnt,
    input logic       spi_req,
    input logic       spi_ack_seen,
    input logic [7:0] hold_byte,
    input logic       bus_req_seen,
    input logic       bus_ack,
    input logic       rx_valid
);
    // R3: strobe lasts one bus cycle
    a_r3_valid_single: assert property (@(posedge bus_clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R3: strobe only alongside a raised acknowledge
    a_r3_valid_with_ack: assert property (@(posedge bus_clk) disable iff (!rst_n)
        rx_valid |-> bus_ack);

    // R4: released chip-select leaves the bit count at zero
    a_r4_cnt_clear: assert property (@(posedge spi_sck) disable iff (!rst_n)
        spi_cs_n |-> (bit_cnt == 3'd0));

    // R6: parked byte frozen while request stays high
    a_r6_hold_stable: assert property (@(posedge spi_sck) disable iff (!rst_n)
        (spi_req && $past(spi_req)) |-> $stable(hold_byte));

    // R6: request rises only after acknowledge seen low
    a_r6_req_rise_clear: assert property (@(posedge spi_sck) disable iff (!rst_n)
        $rose(spi_req) |-> !$past(spi_ack_seen));

    // R7: request falls only after acknowledge seen high
    a_r7_req_fall_after_ack: assert property (@(posedge spi_sck) disable iff (!rst_n)
        $fell(spi_req) |-> $past(spi_ack_seen));

    // R7: acknowledge falls only after request seen low
    a_r7_ack_fall_after_req: assert property (@(posedge bus_clk) disable iff (!rst_n)
        $fell(bus_ack) |-> !$past(bus_req_seen));
endmodule

bind spi_byte_xfer spi_byte_xfer_chk chk_i (
    .bus_clk(bus_clk), .spi_sck(spi_sck), .rst_n(rst_n), .spi_cs_n(spi_cs_n),
    .bit_cnt(bit_cnt), .spi_req(spi_req), .spi_ack_seen(spi_ack_seen),
    .hold_byte(hold_byte), .bus_req_seen(bus_req_seen), .bus_ack(bus_ack),
    .rx_valid(rx_valid)
);

// File: tb/spi_byte_xfer_tb_top.sv
// Bench: full byte-value sweep, aborted bytes, and a stalled bus clock.
module spi_byte_xfer_tb_top;
    localparam int SCK_HALF = 20;

    logic       bus_clk = 1'b0;
    logic       bus_run = 1'b1;
    logic       rst_n   = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_valid;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] got [0:1023];
    int  got_n = 0;
    bit  prev_valid = 0;
    int  width_err = 0;
    int  stab_err = 0;
    bit  have_last = 0;
    logic [7:0] last_byte = 8'h00;

    spi_byte_xfer dut_i (
        .bus_clk(bus_clk), .rst_n(rst_n), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    // 250 MHz bus clock, pausable
    always #2 if (bus_run) bus_clk = ~bus_clk;

    // Record strobes at the falling edge, away from the active edge
    always @(negedge bus_clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                got[got_n] = rx_byte;
                got_n++;
                if (prev_valid) width_err++;
                last_byte = rx_byte;
                have_last = 1;
            end else if (have_last && rx_byte != last_byte) begin
                stab_err++;
            end
            prev_valid = rx_valid;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        spi_mosi = b;
        #SCK_HALF spi_sck = 1'b1;
        #SCK_HALF spi_sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic idle_edges(input int n);
        for (int i = 0; i < n; i++) begin
            #SCK_HALF spi_sck = 1'b1;
            #SCK_HALF spi_sck = 1'b0;
        end
    endtask

    task automatic wait_bus(input int n);
        for (int i = 0; i < n; i++) @(negedge bus_clk);
    endtask

    initial begin
        int base;
        // Reset, with serial edges so the serial-domain flops clear too
        idle_edges(4);
        wait_bus(4);
        check(rx_valid == 1'b0, "R1", "valid in reset", int'(rx_valid), 0);
        check(rx_byte == 8'h00, "R1", "byte in reset", int'(rx_byte), 0);
        @(posedge bus_clk); #1 rst_n = 1'b1;
        wait_bus(5);
        check(rx_valid == 1'b0, "R1", "valid after reset", int'(rx_valid), 0);
        check(got_n == 0, "R1", "no byte before input", got_n, 0);

        // R2/R8: every byte value, back to back in one frame
        base = got_n;
        spi_cs_n = 1'b0;
        for (int v = 0; v < 256; v++) send_byte(8'(v));
        #SCK_HALF spi_cs_n = 1'b1;
        wait_bus(20);
        check(got_n - base == 256, "R8", "sweep byte count", got_n - base, 256);
        for (int v = 0; v < 256; v++)
            check(got[base + v] == 8'(v), "R2", "sweep value", int'(got[base + v]), v);

        // R4: aborted partial bytes must not leak into the next byte
        base = got_n;
        spi_cs_n = 1'b0;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        #SCK_HALF spi_cs_n = 1'b1;
        #SCK_HALF spi_cs_n = 1'b0;
        send_byte(8'h3C);
        #SCK_HALF spi_cs_n = 1'b1;
        wait_bus(20);
        check(got_n - base == 1, "R4", "count after 3-bit abort", got_n - base, 1);
        check(got[base] == 8'h3C, "R4", "byte after 3-bit abort", int'(got[base]), 8'h3C);
        base = got_n;
        #SCK_HALF spi_cs_n = 1'b0;
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        #SCK_HALF spi_cs_n = 1'b1;
        #SCK_HALF spi_cs_n = 1'b0;
        send_byte(8'hA5);
        #SCK_HALF spi_cs_n = 1'b1;
        wait_bus(20);
        check(got_n - base == 1, "R4", "count after 5-bit abort", got_n - base, 1);
        check(got[base] == 8'hA5, "R4", "byte after 5-bit abort", int'(got[base]), 8'hA5);

        // Close the open exchange with idle serial edges
        idle_edges(8);
        wait_bus(10);
        idle_edges(4);

        // R5/R6: bus clock stalled, second byte arrives during open exchange
        base = got_n;
        @(negedge bus_clk); bus_run = 1'b0;
        #SCK_HALF spi_cs_n = 1'b0;
        send_byte(8'h81);
        send_byte(8'h7E);
        #SCK_HALF spi_cs_n = 1'b1;
        #100 bus_run = 1'b1;
        wait_bus(20);
        check(got_n - base == 1, "R5", "count with overrun", got_n - base, 1);
        check(got[base] == 8'h81, "R6", "in-flight byte intact", int'(got[base]), 8'h81);

        // R7: exchange closes on the next byte's edges; next byte accepted
        base = got_n;
        #SCK_HALF spi_cs_n = 1'b0;
        send_byte(8'hC3);
        #SCK_HALF spi_cs_n = 1'b1;
        wait_bus(20);
        check(got_n - base == 1, "R7", "count after exchange", got_n - base, 1);
        check(got[base] == 8'hC3, "R7", "byte after exchange", int'(got[base]), 8'hC3);

        // R3 and R9 summary checks from the monitor
        check(width_err == 0, "R3", "strobe wider than one cycle", width_err, 0);
        check(stab_err == 0, "R9", "byte changed between strobes", stab_err, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        #400000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule